// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is a master-only synchronous serial port behind a small memory-mapped register interface. It generates its own bit clock and a frame pulse. It shifts words of 4 to 16 bits out on a transmit pin and, at the same time, shifts words in from a receive pin. Software sets the port up through two control words, pushes transmit words and pops received words through one data address, and watches a status word or two interrupt lines that report how full the FIFOs are.

A word goes out only while the transmit FIFO holds data. Each word starts with a one-bit-period frame pulse, followed by the data most significant bit first. The bit clock is the selected tick source divided by a fixed two and then by a programmable 1 to 256. The tick source is either every system clock cycle or a pulse on an external tick input. A loopback option feeds the outgoing bit stream straight back to the receiver.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset, all registers read 0 except status. Status reads 0x0009 (transmit FIFO not full, transmit FIFO at or below half). The serial clock, frame, data and both interrupt outputs are low.
- R2: The control registers read back what was written. Control 0 is at 0x60: bits [3:0] word width minus one, [5:4] frame format, bit 7 enable, [15:8] clock rate value S. Control 1 is at 0x64: bit 0 receive interrupt enable, bit 1 transmit interrupt enable, bit 2 loopback, bit 3 clock polarity, bit 4 clock phase (stored only), bit 5 external tick select. Bits [15:6] of control 1 read 0.
- R3: Each word is sent as one bit period with the frame pin high and data low, followed by the word's W bits MSB first. W = field+1, and field values 0 to 2 give W = 4. The next frame starts at once if the transmit FIFO is not empty.
- R4: The bit period is 2×(S+1) ticks. With internal ticks, one tick is one clock cycle. The serial clock pin rests at the polarity bit. Within each bit period it spends the first half at the resting level and the second half inverted. Data and frame change at the start of a period, and the sampling edge is the mid-period edge.
- R5: With the external tick select set, only cycles in which the tick input is high advance the divider. With the select clear, the tick input has no effect.
- R6: Words are sent only while enable is set and the frame format field equals 1. With any other format value, written words stay in the transmit FIFO, and they go out when the format becomes 1.
- R7: During the data bits the receiver samples at the sampling edge, from the receive pin or, in loopback, from the transmit bit stream. It pushes each W-bit word right-justified into the receive FIFO, which is popped by reading the data address 0x6C.
- R8: The transmit FIFO holds 8 words, written through 0x6C while enabled. A write to a full FIFO is dropped. Status bit 0 is 1 while the FIFO is not full.
- R9: The receive FIFO holds 12 words. A word that arrives when it is full is dropped and sets status bit 5. Bit 5 stays set until software writes 1 to bit 5 of the status address 0x74.
- R10: Status bit 1 means the receive FIFO is not empty. Bit 2 means busy: a word is in flight or the transmit FIFO is not empty. Bit 3 means the transmit FIFO holds 4 or fewer words. Bit 4 means the receive FIFO holds 6 or more words.
- R11: The transmit interrupt is status bit 3 ANDed with the transmit interrupt enable. The receive interrupt is status bit 4 ANDed with the receive interrupt enable.
- R12: While enable is clear, both FIFOs are empty, no word is in flight and no frame is produced. Words written before disabling never appear after re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External divider tick, one cycle per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| ssp_sclk | output | 1 | Serial bit clock |
| ssp_frm | output | 1 | Frame pulse |
| ssp_txd | output | 1 | Serial transmit data |
| ssp_rxd | input | 1 | Serial receive data |
| irq_tx | output | 1 | Transmit FIFO service interrupt |
| irq_rx | output | 1 | Receive FIFO service interrupt |

## Verification
The assertions assume that the receive pin and the external tick are synchronous to the system clock. They also assume that the control registers change only while the port is idle, because a divider or width change in the middle of a word is not checked. The stimulus follows both rules. It drives the receive pin as the inverse of the transmit pin, so that the receiver and loopback paths produce different data. It generates the external tick on the falling clock edge every third cycle. It rewrites the control registers only after polling status until busy clears.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [7:0] ADDR_CR0  = 8'h60;
  localparam logic [7:0] ADDR_CR1  = 8'h64;
  localparam logic [7:0] ADDR_DATA = 8'h6C;
  localparam logic [7:0] ADDR_STAT = 8'h74;
  localparam logic [1:0] FMT_TI    = 2'd1;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != FULL_C) && !flush;
  assign do_pop  = pop && (cnt_q != '0) && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST_P) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST_P) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [RW-1:0] rate,
  output logic          launch,
  output logic          sample,
  output logic          half
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;
  logic          wrap;

  assign wrap = run && tick && (cnt_q == rate);

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (!run) begin
      cnt_d  = '0;
      half_d = 1'b1;
    end else if (tick) begin
      if (wrap) begin
        cnt_d  = '0;
        half_d = ~half_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign launch = wrap && half_q;
  assign sample = wrap && !half_q;
  assign half   = half_q;
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
  parameter int DW  = 16,
  localparam int WW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          launch,
  input  logic          sample,
  input  logic [WW-1:0] width,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_word,
  output logic          tx_pop,
  input  logic          rx_in,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          busy,
  output logic          frm,
  output logic          txd
);
  logic          busy_q, busy_d, frm_q, frm_d;
  logic [WW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic [DW:0]   mask;
  logic          word_end, data_phase;

  assign data_phase = busy_q && !frm_q;
  assign word_end   = data_phase && (cnt_q == WW'(1));
  assign tx_pop     = run && launch && tx_avail && (!busy_q || word_end);
  assign mask       = ({{DW{1'b0}}, 1'b1} << width) - 1'b1;

  always_comb begin
    busy_d = busy_q;
    frm_d  = frm_q;
    cnt_d  = cnt_q;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;
    if (!run) begin
      busy_d = 1'b0;
      frm_d  = 1'b0;
      cnt_d  = '0;
      txsh_d = '0;
      rxsh_d = '0;
    end else begin
      if (launch) begin
        if (!busy_q || word_end) begin
          busy_d = tx_avail;
          frm_d  = tx_avail;
          cnt_d  = width;
          txsh_d = tx_word << (WW'(DW) - width);
        end else if (frm_q) begin
          frm_d = 1'b0;
        end else begin
          txsh_d = txsh_q << 1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      if (sample && data_phase) rxsh_d = {rxsh_q[DW-2:0], rx_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      frm_q  <= 1'b0;
      cnt_q  <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      busy_q <= busy_d;
      frm_q  <= frm_d;
      cnt_q  <= cnt_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
    end
  end

  assign rx_push = run && sample && word_end;
  assign rx_word = {rxsh_q[DW-2:0], rx_in} & mask[DW-1:0];
  assign busy    = busy_q;
  assign frm     = frm_q;
  assign txd     = data_phase && txsh_q[DW-1];
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
  parameter int DW       = 16,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 12,
  parameter int RW       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_tick,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        ssp_sclk,
  output logic        ssp_frm,
  output logic        ssp_txd,
  input  logic        ssp_rxd,
  output logic        irq_tx,
  output logic        irq_rx
);
  import ssp_pkg::*;
  localparam int WW  = $clog2(DW + 1);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam logic [TCW-1:0] TX_FULL = TCW'(TX_DEPTH);
  localparam logic [TCW-1:0] TX_HALF = TCW'(TX_DEPTH / 2);
  localparam logic [RCW-1:0] RX_FULL = RCW'(RX_DEPTH);
  localparam logic [RCW-1:0] RX_HALF = RCW'(RX_DEPTH / 2);

  logic [15:0]    cr0_q, cr0_d;
  logic [5:0]     cr1_q, cr1_d;
  logic           ovr_q, ovr_d;
  logic           en, run, tick, launch, sample, half;
  logic [WW-1:0]  width;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;
  logic [DW-1:0]  tx_dout, rx_dout, rx_word;
  logic           tx_pop, rx_push, eng_busy, frm_i, txd_i, rx_in;
  logic           wr_cr0, wr_cr1, wr_data, wr_stat, rd_data;
  logic           st_txnf, st_rxne, st_busy, st_txh, st_rxh;

  assign wr_cr0  = bus_wr && (bus_addr == ADDR_CR0);
  assign wr_cr1  = bus_wr && (bus_addr == ADDR_CR1);
  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

  assign en    = cr0_q[7];
  assign run   = en && (cr0_q[5:4] == FMT_TI);
  assign tick  = cr1_q[5] ? ext_tick : 1'b1;
  assign width = (cr0_q[3:0] < 4'd3) ? WW'(4) : WW'(cr0_q[3:0]) + WW'(1);
  assign rx_in = cr1_q[2] ? txd_i : ssp_rxd;

  always_comb begin
    cr0_d = cr0_q;
    cr1_d = cr1_q;
    ovr_d = ovr_q;
    if (wr_cr0) cr0_d = bus_wdata;
    if (wr_cr1) cr1_d = bus_wdata[5:0];
    if (wr_stat && bus_wdata[5]) ovr_d = 1'b0;
    if (rx_push && (rx_cnt == RX_FULL)) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q <= '0;
      cr1_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cr0_q <= cr0_d;
      cr1_q <= cr1_d;
      ovr_q <= ovr_d;
    end
  end

  ssp_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(!en), .push(wr_data),
    .din(bus_wdata[DW-1:0]), .pop(tx_pop), .dout(tx_dout), .count(tx_cnt));

  ssp_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(!en), .push(rx_push),
    .din(rx_word), .pop(rd_data), .dout(rx_dout), .count(rx_cnt));

  ssp_clkdiv #(.RW(RW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rate(cr0_q[15:8]),
    .launch(launch), .sample(sample), .half(half));

  ssp_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .launch(launch), .sample(sample),
    .width(width), .tx_avail(tx_cnt != '0), .tx_word(tx_dout), .tx_pop(tx_pop),
    .rx_in(rx_in), .rx_push(rx_push), .rx_word(rx_word), .busy(eng_busy),
    .frm(frm_i), .txd(txd_i));

  assign st_txnf = (tx_cnt != TX_FULL);
  assign st_rxne = (rx_cnt != '0);
  assign st_busy = eng_busy || (tx_cnt != '0);
  assign st_txh  = (tx_cnt <= TX_HALF);
  assign st_rxh  = (rx_cnt >= RX_HALF);

  always_comb begin
    case (bus_addr)
      ADDR_CR0:  bus_rdata = cr0_q;
      ADDR_CR1:  bus_rdata = {10'b0, cr1_q};
      ADDR_DATA: bus_rdata = 16'(rx_dout);
      ADDR_STAT: bus_rdata = {10'b0, ovr_q, st_rxh, st_txh, st_busy, st_rxne, st_txnf};
      default:   bus_rdata = '0;
    endcase
  end

  assign ssp_sclk = cr1_q[3] ^ (eng_busy && half);
  assign ssp_frm  = frm_i;
  assign ssp_txd  = txd_i;
  assign irq_tx   = cr1_q[1] && st_txh;
  assign irq_rx   = cr1_q[0] && st_rxh;
endmodule

// File: rtl/ssp_ctrl_chk.sv
module ssp_ctrl_chk #(
  parameter int TXD = 8,
  parameter int RXD = 12,
  localparam int TCW = $clog2(TXD + 1),
  localparam int RCW = $clog2(RXD + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           run,
  input logic           ovr,
  input logic           ssp_frm,
  input logic           ssp_txd,
  input logic           irq_rx,
  input logic [TCW-1:0] tx_cnt,
  input logic [RCW-1:0] rx_cnt
);
  AST_FRAME_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ssp_frm |-> !ssp_txd);                                            // R3
  AST_FRAME_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ssp_frm);                                               // R6
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TCW'(TXD));                                             // R8
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RCW'(RXD));                                             // R9
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> (rx_cnt == RCW'(RXD)));                            // R9
  AST_IRQ_RX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rx_cnt != '0));                                       // R11
  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_cnt == '0) && (rx_cnt == '0));                        // R12
endmodule

bind ssp_ctrl ssp_ctrl_chk #(.TXD(TX_DEPTH), .RXD(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run), .ovr(ovr_q),
  .ssp_frm(ssp_frm), .ssp_txd(ssp_txd), .irq_rx(irq_rx),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/ssp_ctrl_test.sv
module ssp_ctrl_test;
  localparam logic [7:0] A_CR0 = 8'h60, A_CR1 = 8'h64, A_DAT = 8'h6C, A_STA = 8'h74;

  logic clk = 0, rst_n = 0, ext_tick = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic ssp_sclk, ssp_frm, ssp_txd, ssp_rxd, irq_tx, irq_rx;

  int nchk = 0, nerr = 0, cyc = 0, ext_div = 0;
  bit done = 0;
  bit pol = 0;
  int mon_w = 16;
  bit collecting = 0;
  int bits = 0, frm_cyc = 0, bad_frame = 0;
  logic [15:0] acc = 0;
  logic [15:0] got[$];
  int per_log[$];
  logic [15:0] words[16];

  assign ssp_rxd = ~ssp_txd;

  ssp_ctrl uut (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    ext_div = (ext_div == 2) ? 0 : ext_div + 1;
    ext_tick = (ext_div == 0);
  end

  // pin monitor: decodes frames at the sampling edge
  always @(posedge ssp_sclk or negedge ssp_sclk) begin
    if ((ssp_sclk ^ pol) == 1'b1) begin
      if (ssp_frm) begin
        if (collecting) bad_frame++;
        collecting = 1; bits = 0; acc = 0; frm_cyc = cyc;
      end else if (collecting) begin
        acc = {acc[14:0], ssp_txd};
        if (bits == 0) per_log.push_back(cyc - frm_cyc);
        bits++;
        if (bits == mon_w) begin
          got.push_back(acc);
          collecting = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STA, s);
      if (!s[2]) return;
    end
    check(0, "R10 busy never cleared", 1, 0);
  endtask

  function automatic int width_of(input int dss);
    return (dss < 3) ? 4 : dss + 1;
  endfunction

  function automatic logic [15:0] mask_of(input int w);
    return 16'((32'd1 << w) - 1);
  endfunction

  task automatic run_round(input int dss, input int scr, input bit p, input bit lb,
                           input bit ext, input int n);
    int w; logic [15:0] m, d, e; int per;
    w = width_of(dss); m = mask_of(w);
    per = 2 * (scr + 1) * (ext ? 3 : 1);
    pol = p; mon_w = w;
    wr(A_CR1, {10'b0, ext, 1'b0, p, lb, 2'b00});
    wr(A_CR0, 16'((scr << 8) | 8'h90 | dss));
    got.delete(); per_log.delete();
    for (int i = 0; i < n; i++) begin
      words[i] = 16'($urandom);
      wr(A_DAT, words[i]);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    check(got.size() == n, "R6 word count", got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      check(got[i] == (words[i] & m), "R3 serial word", got[i], words[i] & m);
    foreach (per_log[i])
      check(per_log[i] == per, ext ? "R5 ext bit period" : "R4 bit period", per_log[i], per);
    for (int i = 0; i < n; i++) begin
      rd(A_DAT, d);
      e = lb ? (words[i] & m) : (~words[i] & m);
      check(d == e, "R7 received word", d, e);
    end
    rd(A_STA, d);
    check(d[1] == 0, "R10 rx empty after reads", d[1], 0);
    check(ssp_sclk == p, "R4 idle clock level", ssp_sclk, p);
    wr(A_CR0, 16'h0000);
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({ssp_sclk, ssp_frm, ssp_txd, irq_tx, irq_rx} == 0, "R1 pins", ssp_sclk, 0);
    rd(A_STA, d); check(d == 16'h0009, "R1 status", d, 9);
    rd(A_CR0, d); check(d == 0, "R1 cr0", d, 0);
    rd(A_CR1, d); check(d == 0, "R1 cr1", d, 0);
    // R2 readback
    wr(A_CR1, 16'hFFFF); rd(A_CR1, d); check(d == 16'h003F, "R2 cr1 readback", d, 16'h3F);
    wr(A_CR1, 16'h0000);
    wr(A_CR0, 16'hAB37); rd(A_CR0, d); check(d == 16'hAB37, "R2 cr0 readback", d, 16'hAB37);
    wr(A_CR0, 16'h0000);

    // directed rounds
    run_round(15, 3, 0, 1, 0, 8);
    run_round(0, 0, 1, 0, 0, 3);
    run_round(7, 1, 0, 0, 1, 4);
    run_round(2, 2, 1, 1, 0, 2);
    // R5: ext ticks ignored when select clear covered by internal rounds above
    for (int r = 0; r < 6; r++)
      run_round($urandom % 16, $urandom % 4, 1'($urandom), 1'($urandom),
                1'($urandom), 1 + $urandom % 8);

    // R8/R10/R11/R6 transmit FIFO filling with a non-TI format
    pol = 0; mon_w = 16; got.delete(); per_log.delete();
    wr(A_CR1, 16'h0002);
    wr(A_CR0, 16'h008F);
    for (int i = 0; i < 4; i++) begin words[i] = 16'($urandom); wr(A_DAT, words[i]); end
    rd(A_STA, d); check(d[3] == 1, "R10 tx at half", d[3], 1);
    check(irq_tx == 1, "R11 irq_tx at half", irq_tx, 1);
    words[4] = 16'($urandom); wr(A_DAT, words[4]);
    rd(A_STA, d); check(d[3] == 0, "R10 tx above half", d[3], 0);
    check(irq_tx == 0, "R11 irq_tx above half", irq_tx, 0);
    for (int i = 5; i < 8; i++) begin words[i] = 16'($urandom); wr(A_DAT, words[i]); end
    rd(A_STA, d); check(d[0] == 0, "R8 tx full flag", d[0], 0);
    wr(A_DAT, 16'hDEAD);
    repeat (50) @(negedge clk);
    check(got.size() == 0, "R6 no output in other format", got.size(), 0);
    wr(A_CR0, 16'h009F);
    wait_idle(); repeat (4) @(negedge clk);
    check(got.size() == 8, "R8 full write dropped", got.size(), 8);
    for (int i = 0; i < 8 && i < got.size(); i++)
      check(got[i] == words[i], "R8 fifo order", got[i], words[i]);
    check(irq_tx == 1, "R11 irq_tx after drain", irq_tx, 1);
    wr(A_CR1, 16'h0000);
    check(irq_tx == 0, "R11 irq_tx disabled", irq_tx, 0);
    wr(A_CR0, 16'h0000);

    // R9/R10/R11 receive overrun in loopback, width 8
    mon_w = 8; got.delete(); per_log.delete();
    wr(A_CR1, 16'h0005);
    wr(A_CR0, 16'h0097);
    for (int i = 0; i < 8; i++) begin words[i] = 16'($urandom); wr(A_DAT, words[i]); end
    wait_idle();
    rd(A_STA, d); check(d[4] == 1 && d[5] == 0, "R10 rx half no overrun", d, 16'h12);
    check(irq_rx == 1, "R11 irq_rx", irq_rx, 1);
    for (int i = 8; i < 13; i++) begin words[i] = 16'($urandom); wr(A_DAT, words[i]); end
    wait_idle(); repeat (4) @(negedge clk);
    rd(A_STA, d); check(d[5] == 1, "R9 overrun set", d[5], 1);
    for (int i = 0; i < 6; i++) begin
      rd(A_DAT, d); check(d == (words[i] & 16'h00FF), "R9 rx order", d, words[i] & 16'hFF);
    end
    rd(A_STA, d); check(d[4] == 1, "R10 rx six entries", d[4], 1);
    rd(A_DAT, d); check(d == (words[6] & 16'h00FF), "R9 rx order", d, words[6] & 16'hFF);
    rd(A_STA, d); check(d[4] == 0, "R10 rx five entries", d[4], 0);
    check(irq_rx == 0, "R11 irq_rx below half", irq_rx, 0);
    for (int i = 7; i < 12; i++) begin
      rd(A_DAT, d); check(d == (words[i] & 16'h00FF), "R9 rx order", d, words[i] & 16'hFF);
    end
    rd(A_STA, d); check(d[1] == 0, "R9 thirteenth word dropped", d[1], 0);
    check(d[5] == 1, "R9 overrun sticky", d[5], 1);
    wr(A_STA, 16'h0020);
    rd(A_STA, d); check(d[5] == 0, "R9 overrun cleared", d[5], 0);
    wr(A_CR1, 16'h0000);
    wr(A_CR0, 16'h0000);

    // R12 disable flushes
    mon_w = 16; got.delete();
    wr(A_CR0, 16'h008F);
    for (int i = 0; i < 3; i++) wr(A_DAT, 16'h1234);
    rd(A_STA, d); check(d[2] == 1, "R10 busy with queued words", d[2], 1);
    wr(A_CR0, 16'h000F);
    rd(A_STA, d); check(d == 16'h0009, "R12 status after disable", d, 9);
    wr(A_CR0, 16'h009F);
    repeat (400) @(negedge clk);
    check(got.size() == 0, "R12 no stale frames", got.size(), 0);
    rd(A_STA, d); check(d[2] == 0, "R12 idle after re-enable", d[2], 0);
    check(bad_frame == 0, "R3 frame inside word", bad_frame, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule